// File: doc/BRIEF.md
# Keyed configuration item port

This block is a read-only configuration store seen by host software through a small bus slave. Software writes a 16-bit key to choose one stored item, then pulls the item's bytes through a data port. An internal byte cursor advances with every byte delivered, and a new selection always rewinds it. Item lengths and contents come from a synthesizable table computed from the parameters, split into two independent banks: a generic bank and an architecture-local bank.

The slave has three targets, chosen by `req_port_i`. The selector target takes 2-byte key writes. The data target returns 1, 2, 4 or 8 bytes per read. The first byte fetched lands in the most significant byte of the result. The combined target merges the two in one narrow window. Rejected accesses complete with a zero response and change nothing. Each request gets its response in the next cycle.

Top module: `cfg_item_port`

## Requirements
- R1: After reset the signature item (generic bank, index 0) is selected at offset 0; it holds the four bytes 0x43, 0x46, 0x47, 0x50 in that order.
- R2: An accepted select sets the byte offset to zero, whether the key is valid or not; a re-select of the same key restarts it at byte 0.
- R3: Key bit 15 picks the bank (0 generic, 1 architecture-local); bits 13:0 are the index and bit 14 is ignored. An index at or above NUM_ITEMS makes the selection invalid, and every byte read from it is zero.
- R4: A byte read returns the item byte at the current offset and advances the offset by one. Once the offset reaches the item length, reads return zero and the offset stays put.
- R5: A data-port read of N = 2^req_size_i bytes returns N successive item bytes, the first in bits 8N-1:8N-8 and the last in bits 7:0, with bits above 8N zero. Bytes past the end read as zero, and the offset advances only by the number of real bytes.
- R6: Generic bank: index 0 is the signature (length 4), index 1 is the identification item (length 4), index 2 has length 0, and any other index i has length i+3 with byte j equal to {i[3:0], j[3:0]}. Local bank: index i has length 2i+1 and byte j equal to 0x80 | i[2:0]<<4 | j[3:0].
- R7: The identification item is a little-endian 32-bit word whose bit 0 is 1 and whose bit 1 equals DMA_EN; its other bits are 0.
- R8: Combined port (req_port_i=0): a read of size code 0 returns one data byte, a write of size code 1 selects key req_wdata_i[15:0], and a write of size code 0 is accepted with no effect. Any other size is rejected.
- R9: Selector port (req_port_i=1) accepts only writes of size code 1; all else is rejected.
- R10: Data port (req_port_i=2) accepts accesses only at req_addr_i=0 and of at most DATA_BYTES bytes. Writes there are accepted and discarded. Port code 3 rejects everything.
- R11: A rejected access answers with rsp_ok_o=0 and rsp_rdata_o=0 and leaves the selection and offset unchanged.
- R12: rsp_valid_o is high exactly in the cycle after a cycle with req_valid_i high. Accepted accesses set rsp_ok_o=1, and writes return zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request this cycle |
| req_write_i | input | 1 | 1 write, 0 read |
| req_port_i | input | 2 | Target: 0 combined, 1 selector, 2 data, 3 none |
| req_size_i | input | 2 | Access size as log2 of bytes |
| req_addr_i | input | 3 | Byte address within the target |
| req_wdata_i | input | 8*DATA_BYTES | Write data; key in bits 15:0 |
| rsp_valid_o | output | 1 | Response for the previous cycle's request |
| rsp_ok_o | output | 1 | Access accepted |
| rsp_rdata_o | output | 8*DATA_BYTES | Read data, first byte most significant |

## Verification
Two functions can meet in a single wide read: delivering real item bytes and zero-filling past the item's end. The same access also moves the offset only part of the way. The bench provokes this by sweeping every item with every read width, so most widths cross the end partway through an access. It predicts both the packed value and the next offset from the requirement text. A follow-up read checks that the offset stopped at the length. The legality sweep sets up a known partial offset before each access, then reads the next byte. That shows through the data port whether the access moved the cursor, selected, or did nothing.

// File: rtl/cfg_item_pkg.sv
package cfg_item_pkg;

  typedef enum logic [1:0] {
    PORT_COMB = 2'd0,
    PORT_SEL  = 2'd1,
    PORT_DATA = 2'd2,
    PORT_NONE = 2'd3
  } port_e;

  typedef enum logic [1:0] {
    ACC_REJECT = 2'd0,
    ACC_SELECT = 2'd1,
    ACC_READ   = 2'd2,
    ACC_DROP   = 2'd3
  } acc_e;

  localparam logic [31:0] SIG_WORD = 32'h4346_4750;

  function automatic logic [15:0] item_len(input logic bank, input logic [15:0] idx);
    logic [15:0] l;
    if (!bank) begin
      case (idx)
        16'd0:   l = 16'd4;
        16'd1:   l = 16'd4;
        16'd2:   l = 16'd0;
        default: l = idx + 16'd3;
      endcase
    end else begin
      l = {idx[14:0], 1'b1};
    end
    return l;
  endfunction

  function automatic logic [7:0] item_byte(input logic bank, input logic [15:0] idx,
                                           input logic [15:0] off, input logic dma_en);
    logic [7:0] b;
    if (!bank) begin
      case (idx)
        16'd0: begin
          case (off[1:0])
            2'd0:    b = SIG_WORD[31:24];
            2'd1:    b = SIG_WORD[23:16];
            2'd2:    b = SIG_WORD[15:8];
            default: b = SIG_WORD[7:0];
          endcase
        end
        16'd1:   b = (off == 16'd0) ? {6'd0, dma_en, 1'b1} : 8'h00;
        default: b = {idx[3:0], off[3:0]};
      endcase
    end else begin
      b = {1'b1, idx[2:0], off[3:0]};
    end
    return b;
  endfunction

endpackage

// File: rtl/cfg_item_decode.sv
module cfg_item_decode
  import cfg_item_pkg::*;
#(
  parameter int DATA_BYTES = 8
) (
  input  logic       valid_i,
  input  logic       write_i,
  input  logic [1:0] port_i,
  input  logic [1:0] size_i,
  input  logic [2:0] addr_i,
  output acc_e       acc_o
);
  logic size_fits;
  assign size_fits = (4'd1 << size_i) <= 4'(DATA_BYTES);

  always_comb begin
    acc_o = ACC_REJECT;
    if (valid_i) begin
      case (port_e'(port_i))
        PORT_COMB: begin
          if (write_i && size_i == 2'd1)       acc_o = ACC_SELECT;
          else if (write_i && size_i == 2'd0)  acc_o = ACC_DROP;
          else if (!write_i && size_i == 2'd0) acc_o = ACC_READ;
        end
        PORT_SEL: begin
          if (write_i && size_i == 2'd1) acc_o = ACC_SELECT;
        end
        PORT_DATA: begin
          if (addr_i == 3'd0 && size_fits) acc_o = write_i ? ACC_DROP : ACC_READ;
        end
        default: acc_o = ACC_REJECT;
      endcase
    end
  end
endmodule

// File: rtl/cfg_item_window.sv
module cfg_item_window
  import cfg_item_pkg::*;
#(
  parameter int  LANES  = 8,
  parameter int  OFF_W  = 16,
  parameter int  IDX_W  = 14,
  parameter bit  DMA_EN = 1'b1
) (
  input  logic             sel_ok_i,
  input  logic             bank_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [7:0]       lane_o [LANES],
  output logic [OFF_W-1:0] len_o,
  output logic [OFF_W-1:0] avail_o
);
  logic [15:0] idx16;
  assign idx16   = 16'(idx_i);
  assign len_o   = sel_ok_i ? OFF_W'(item_len(bank_i, idx16)) : '0;
  assign avail_o = (off_i < len_o) ? (len_o - off_i) : '0;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [OFF_W:0] pos;
    assign pos = {1'b0, off_i} + (OFF_W+1)'(b);
    assign lane_o[b] = (sel_ok_i && pos < {1'b0, len_o})
                       ? item_byte(bank_i, idx16, 16'(pos), DMA_EN) : 8'h00;
  end
endmodule

// File: rtl/cfg_item_cursor.sv
module cfg_item_cursor #(
  parameter int KEY_W     = 16,
  parameter int IDX_W     = 14,
  parameter int NUM_ITEMS = 4,
  parameter int OFF_W     = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             select_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             read_i,
  input  logic [OFF_W-1:0] adv_i,
  output logic [KEY_W-1:0] key_o,
  output logic             ok_o,
  output logic [OFF_W-1:0] off_o
);
  logic key_in_range;
  assign key_in_range = 32'(key_i[IDX_W-1:0]) < NUM_ITEMS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_o <= '0;
      ok_o  <= 1'b1;
      off_o <= '0;
    end else if (select_i) begin
      key_o <= key_i;
      ok_o  <= key_in_range;
      off_o <= '0;
    end else if (read_i) begin
      off_o <= off_o + adv_i;
    end
  end
endmodule

// File: rtl/cfg_item_port.sv
module cfg_item_port
  import cfg_item_pkg::*;
#(
  parameter int KEY_W      = 16,
  parameter int BANK_BIT   = 15,
  parameter int IDX_W      = 14,
  parameter int NUM_ITEMS  = 4,
  parameter int DATA_BYTES = 8,
  parameter int OFF_W      = 16,
  parameter bit DMA_EN     = 1'b1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  input  logic                    req_write_i,
  input  logic [1:0]              req_port_i,
  input  logic [1:0]              req_size_i,
  input  logic [2:0]              req_addr_i,
  input  logic [8*DATA_BYTES-1:0] req_wdata_i,
  output logic                    rsp_valid_o,
  output logic                    rsp_ok_o,
  output logic [8*DATA_BYTES-1:0] rsp_rdata_o
);
  localparam int RD_W = 8 * DATA_BYTES;

  acc_e             acc;
  logic [KEY_W-1:0] cur_key;
  logic             cur_ok;
  logic [OFF_W-1:0] cur_off;
  logic [OFF_W-1:0] cur_len;
  logic [OFF_W-1:0] avail;
  logic [7:0]       lane [DATA_BYTES];
  logic [OFF_W-1:0] rd_bytes;
  logic [OFF_W-1:0] adv;
  logic [RD_W-1:0]  rd_data;

  cfg_item_decode #(.DATA_BYTES(DATA_BYTES)) u_decode (
    .valid_i (req_valid_i),
    .write_i (req_write_i),
    .port_i  (req_port_i),
    .size_i  (req_size_i),
    .addr_i  (req_addr_i),
    .acc_o   (acc)
  );

  cfg_item_cursor #(
    .KEY_W(KEY_W), .IDX_W(IDX_W), .NUM_ITEMS(NUM_ITEMS), .OFF_W(OFF_W)
  ) u_cursor (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .select_i (acc == ACC_SELECT),
    .key_i    (req_wdata_i[KEY_W-1:0]),
    .read_i   (acc == ACC_READ),
    .adv_i    (adv),
    .key_o    (cur_key),
    .ok_o     (cur_ok),
    .off_o    (cur_off)
  );

  cfg_item_window #(
    .LANES(DATA_BYTES), .OFF_W(OFF_W), .IDX_W(IDX_W), .DMA_EN(DMA_EN)
  ) u_window (
    .sel_ok_i (cur_ok),
    .bank_i   (cur_key[BANK_BIT]),
    .idx_i    (cur_key[IDX_W-1:0]),
    .off_i    (cur_off),
    .lane_o   (lane),
    .len_o    (cur_len),
    .avail_o  (avail)
  );

  // combined target always moves one byte
  assign rd_bytes = (port_e'(req_port_i) == PORT_COMB) ? OFF_W'(1) : (OFF_W'(1) << req_size_i);
  assign adv      = (rd_bytes < avail) ? rd_bytes : avail;

  // first lane fetched goes to the most significant used byte
  always_comb begin
    rd_data = '0;
    for (int b = 0; b < DATA_BYTES; b++) begin
      if (OFF_W'(b) < rd_bytes) begin
        rd_data = rd_data | (RD_W'(lane[b]) << (8 * (32'(rd_bytes) - 1 - b)));
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_ok_o    <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_ok_o    <= req_valid_i && (acc != ACC_REJECT);
      rsp_rdata_o <= (acc == ACC_READ) ? rd_data : '0;
    end
  end
endmodule

// File: rtl/cfg_item_port_chk.sv
module cfg_item_port_chk #(
  parameter int KEY_W = 16,
  parameter int OFF_W = 16,
  parameter int RD_W  = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             rsp_valid_o,
  input logic             rsp_ok_o,
  input logic [RD_W-1:0]  rsp_rdata_o,
  input logic [1:0]       acc,
  input logic [KEY_W-1:0] cur_key,
  input logic             cur_ok,
  input logic [OFF_W-1:0] cur_off,
  input logic [OFF_W-1:0] cur_len
);
  a_r12_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  a_r12_no_spurious_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  a_r11_reject_zero_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ok_o) |-> (rsp_rdata_o == '0));

  a_r11_reject_keeps_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && acc == 2'd0) |=> ($stable(cur_off) && $stable(cur_key) && $stable(cur_ok)));

  a_r10_drop_keeps_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc == 2'd3) |=> ($stable(cur_off) && $stable(cur_key)));

  a_r2_select_clears_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc == 2'd1) |=> (cur_off == '0));

  a_r4_offset_within_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_ok |-> (cur_off <= cur_len));

  a_r3_invalid_offset_stays_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cur_ok && acc != 2'd1) |=> (cur_off == '0));
endmodule

bind cfg_item_port cfg_item_port_chk #(
  .KEY_W(KEY_W), .OFF_W(OFF_W), .RD_W(8*DATA_BYTES)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_ok_o    (rsp_ok_o),
  .rsp_rdata_o (rsp_rdata_o),
  .acc         (acc),
  .cur_key     (cur_key),
  .cur_ok      (cur_ok),
  .cur_off     (cur_off),
  .cur_len     (cur_len)
);

// File: tb/cfg_item_port_bench.sv
module cfg_item_port_bench;
  localparam int  NUM = 4;
  localparam bit  DMA = 1'b1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_port = '0;
  logic [1:0]  req_size = '0;
  logic [2:0]  req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ok;
  logic [63:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  bit         m_bank;
  int         m_idx;
  bit         m_valid;
  int         m_off;

  always #5 clk = ~clk;

  cfg_item_port u_cfg_item_port (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_port_i(req_port), .req_size_i(req_size), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid), .rsp_ok_o(rsp_ok),
    .rsp_rdata_o(rsp_rdata)
  );

  function automatic int mlen(bit bank, int idx);
    if (idx >= NUM) return 0;
    if (bank) return 2 * idx + 1;
    if (idx == 0 || idx == 1) return 4;
    if (idx == 2) return 0;
    return idx + 3;
  endfunction

  function automatic logic [7:0] mbyte(bit bank, int idx, int off);
    logic [31:0] sig;
    sig = 32'h43464750;
    if (bank) return 8'(8'h80 | ((idx & 7) << 4) | (off & 15));
    if (idx == 0) return sig[31 - 8*off -: 8];
    if (idx == 1) return (off == 0) ? 8'(1 + 2 * int'(DMA)) : 8'h00;
    return 8'(((idx & 15) << 4) | (off & 15));
  endfunction

  task automatic check(bit cond, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] port, input bit wr, input logic [1:0] size,
                        input logic [2:0] addr, input logic [63:0] wd,
                        output bit vld, output bit ok, output logic [63:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_port = port; req_size = size;
    req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    vld = rsp_valid; ok = rsp_ok; rd = rsp_rdata;
  endtask

  task automatic select(input logic [15:0] key, input logic [1:0] port);
    bit v, ok; logic [63:0] rd;
    access(port, 1'b1, 2'd1, 3'd0, {48'd0, key}, v, ok, rd);
    m_bank = key[15]; m_idx = int'(key[13:0]); m_valid = m_idx < NUM; m_off = 0;
  endtask

  // expected packed value for an n-byte read; advances model offset
  function automatic logic [63:0] mread(int n);
    logic [63:0] e;
    int len;
    e = '0;
    len = m_valid ? mlen(m_bank, m_idx) : 0;
    for (int b = 0; b < n; b++) begin
      e = (e << 8) | ((m_off + b < len) ? 64'(mbyte(m_bank, m_idx, m_off + b)) : 64'd0);
    end
    for (int b = 0; b < n; b++) if (m_off < len) m_off++;
    return e;
  endfunction

  task automatic read_check(input logic [1:0] port, input logic [1:0] size, input string tag);
    bit v, ok; logic [63:0] rd, e;
    int n;
    n = (port == 2'd0) ? 1 : (1 << size);
    e = mread(n);
    access(port, 1'b0, size, 3'd0, 64'd0, v, ok, rd);
    check(v && ok && rd == e, tag, rd, e);
  endtask

  function automatic int exp_acc(int port, bit wr, int size, int addr);
    // 0 reject, 1 select, 2 read, 3 drop
    if (port == 0) begin
      if (wr && size == 1) return 1;
      if (wr && size == 0) return 3;
      if (!wr && size == 0) return 2;
      return 0;
    end
    if (port == 1) return (wr && size == 1) ? 1 : 0;
    if (port == 2) begin
      if (addr != 0) return 0;
      return wr ? 3 : 2;
    end
    return 0;
  endfunction

  initial begin
    #(10 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit v, ok; logic [63:0] rd, e;
    int a;
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0 && rsp_ok == 1'b0 && rsp_rdata == 64'd0, "R12 reset outputs",
          {62'd0, rsp_valid, rsp_ok}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(rsp_valid == 1'b0, "R12 idle no response", {63'd0, rsp_valid}, 64'd0);

    // R1: signature selected out of reset
    m_bank = 0; m_idx = 0; m_valid = 1; m_off = 0;
    access(2'd2, 1'b0, 2'd2, 3'd0, 64'd0, v, ok, rd);
    check(v && ok && rd == 64'h43464750, "R1 reset signature", rd, 64'h43464750);
    m_off = 4;
    read_check(2'd2, 2'd0, "R4 R1 signature end zero");

    // R3 R4 R6: byte sweep over every key, both banks, bit 14 toggled
    for (int bank = 0; bank < 2; bank++) begin
      for (int idx = 0; idx < NUM + 2; idx++) begin
        logic [15:0] key;
        key = 16'(idx) | (16'(bank) << 15) | ((idx % 2 == 1) ? 16'h4000 : 16'h0);
        select(key, (idx % 2 == 0) ? 2'd0 : 2'd1);
        for (int j = 0; j < mlen(bank[0], idx) + 2; j++)
          read_check((j % 2 == 0) ? 2'd0 : 2'd2, 2'd0, "R4 R6 R3 byte sweep");
      end
    end

    // R5: every width over every valid item, crossing the end
    for (int bank = 0; bank < 2; bank++)
      for (int idx = 0; idx < NUM; idx++)
        for (int sz = 0; sz < 4; sz++) begin
          select(16'(idx) | (16'(bank) << 15), 2'd1);
          for (int k = 0; k < (mlen(bank[0], idx) >> sz) + 2; k++)
            read_check(2'd2, 2'(sz), "R5 wide read");
        end

    // R2: reselect mid item, and after invalid key
    select(16'h8003, 2'd0);
    read_check(2'd2, 2'd1, "R2 partial read");
    select(16'h8003, 2'd0);
    read_check(2'd0, 2'd0, "R2 reselect restarts");
    select(16'h0123, 2'd1);
    read_check(2'd2, 2'd3, "R3 invalid key zeros");
    select(16'h8003, 2'd1);
    read_check(2'd2, 2'd0, "R2 valid after invalid");

    // R7: identification word, little-endian bytes
    select(16'h0001, 2'd1);
    access(2'd2, 1'b0, 2'd2, 3'd0, 64'd0, v, ok, rd);
    e = {rd[7:0], rd[15:8], rd[23:16], rd[31:24]};
    check(ok && e == 64'(1 + 2 * int'(DMA)), "R7 identification bits", e, 64'(1 + 2 * int'(DMA)));

    // R8 R9 R10 R11 R12: legality sweep
    for (int port = 0; port < 4; port++)
      for (int wr = 0; wr < 2; wr++)
        for (int sz = 0; sz < 4; sz++)
          for (int ad = 0; ad < 2; ad++) begin
            select(16'h8003, 2'd1);
            read_check(2'd2, 2'd0, "R4 sweep setup");
            a = exp_acc(port, wr[0], sz, ad);
            e = 64'd0;
            if (a == 2) e = mread((port == 0) ? 1 : (1 << sz));
            access(2'(port), wr[0], 2'(sz), 3'(ad), 64'h0, v, ok, rd);
            check(v, "R12 response valid", {63'd0, v}, 64'd1);
            check(ok == (a != 0), "R8 R9 R10 accept flag", {63'd0, ok}, 64'(a != 0));
            check(rd == e, (a == 0) ? "R11 reject data zero" : "R10 response data", rd, e);
            if (a == 1) begin
              m_bank = 0; m_idx = 0; m_valid = 1; m_off = 0;
            end
            read_check(2'd2, 2'd0, (a == 0) ? "R11 state kept" : "R8 R10 following byte");
          end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule